// File: doc/BRIEF.md
# Protected Flash Word-Program Sequencer

This block is a synchronous command front end for a two-bank flash model. It samples the host's write strobe and bank enable in the system clock domain. A host write is the interval in which both strobes are low. The block captures the address at the start of a write and the data at its end. It watches the stream of completed writes for a three-write unlock key. The write after the key is taken as a single program command, carrying the target word address and the new word value.

When the program command arrives, the block marks the addressed bank busy for a fixed number of clocks, which stands for the internal program time. During that time every further write is dropped. Host reads of the busy bank return polling status instead of array data. Reads of the other bank pass array data through unchanged. In the last busy cycle the block issues a one-cycle program request to an external array model. That request carries the bitwise AND of the stored word and the new word, because programming can only clear bits.

Top module: `flash_prog_seq`

## Requirements
- R1: After synchronous reset, `bank_busy` is 00, `prog_req` is 0 and `rdata` is 0 while `oe_n` is high.
- R2: The command address is the value of `addr` in the first clock in which both `we_n` and `ce_n` are sampled low, whichever strobe fell last. Later address changes inside the same write are not used.
- R3: The command data is the value of `wdata` in the first clock in which either `we_n` or `ce_n` is sampled high again, whichever strobe rose first. That clock completes the write, and a later rise of the other strobe does nothing.
- R4: The unlock key is three completed writes whose address bits [14:0] and data bits [7:0] are, in order, 5555h/AAh, 2AAAh/55h and 5555h/A0h. Any write that does not match the expected step returns the sequence to its start, and the following write then programs nothing.
- R5: The write after a complete key starts programming. `bank_busy[addr[15]]` is set from the clock after that write completes and stays high for exactly `PGM_CYCLES` clocks. The other flag stays low.
- R6: Writes completed while a bank is busy are ignored. They set no busy flag and cause no program request, whatever their contents.
- R7: While reading the busy bank (`oe_n`, `ce_n` low), `rdata` bit 7 is the complement of bit 7 of the new word and all other bits are 0, except bit 6. Bit 6 starts at 0 for each program and inverts after every read of the busy bank ends.
- R8: A read of the bank that is not busy returns `arr_rdata`. `rdata` is 0 whenever `oe_n` or `ce_n` is high.
- R9: `prog_req` is high for exactly one cycle, the last busy cycle. `prog_addr` is the captured address and `prog_wdata` is the new word ANDed with `arr_pdata`.
- R10: After programming ends, reads of the programmed word return the array contents, which hold the ANDed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Sampled write strobe, active low |
| ce_n | input | 1 | Sampled flash bank enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Word address; bit 15 picks the bank |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| arr_rdata | input | 16 | Array word at `addr` |
| arr_pdata | input | 16 | Array word at `prog_addr` |
| bank_busy | output | 2 | Per-bank programming flag |
| prog_req | output | 1 | One-cycle array write request |
| prog_addr | output | 16 | Address of the word being programmed |
| prog_wdata | output | 16 | Value to store (new AND old) |

## Verification
The hardest situation to reach from the ports is a write whose two strobes overlap unevenly. In such a write the address bus and data bus change between the two falling edges and between the two rising edges. The bench builds one program command this way. It lowers the write strobe first while a wrong address is on the bus, then puts the real address up before lowering the bank enable. It then changes the address again before the end of the write. At the end it raises the bank enable first, and only then corrupts the data and raises the write strobe. Only the correct edge rules leave the right value at the right word. The bench also sends a complete key and program command while the other bank is busy, and checks that nothing follows from it.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int AW = 16;
    localparam int DW = 16;

    localparam logic [14:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [14:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [7:0]  KEY_BYTE_1  = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_2  = 8'h55;
    localparam logic [7:0]  KEY_BYTE_3  = 8'hA0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_ARMED,
        SQ_BUSY
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_cmd_t;

    function automatic logic key_hit(input wr_cmd_t c,
                                     input logic [14:0] ka,
                                     input logic [7:0] kd);
        return (c.addr[14:0] == ka) && (c.data[7:0] == kd);
    endfunction

endpackage

// File: rtl/fps_strobe.sv
module fps_strobe
    import fps_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we_n,
    input  logic          ce_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_done,
    output wr_cmd_t       cmd
);

    logic          wr_on;
    logic          wr_on_q;
    logic [AW-1:0] addr_cap;

    // a write is active only while both strobes are low
    assign wr_on = ~we_n & ~ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_on_q  <= 1'b0;
            addr_cap <= '0;
        end else begin
            wr_on_q <= wr_on;
            if (wr_on && !wr_on_q)
                addr_cap <= addr;
        end
    end

    // first strobe to rise ends the write; data is taken from the bus now
    assign wr_done  = wr_on_q & ~wr_on;
    assign cmd.addr = addr_cap;
    assign cmd.data = wdata;

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int PGM_CYCLES = 2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_done,
    input  wr_cmd_t       cmd,
    output logic [1:0]    bank_busy,
    output logic          prog_start,
    output logic          prog_req,
    output wr_cmd_t       target
);

    localparam int CNT_W = (PGM_CYCLES > 2) ? $clog2(PGM_CYCLES) : 1;

    seq_state_e       state;
    logic [CNT_W-1:0] remain;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            remain <= '0;
            target <= '0;
        end else begin
            unique case (state)
                SQ_IDLE:
                    if (wr_done && key_hit(cmd, KEY_ADDR_HI, KEY_BYTE_1))
                        state <= SQ_KEY1;
                SQ_KEY1:
                    if (wr_done)
                        state <= key_hit(cmd, KEY_ADDR_LO, KEY_BYTE_2) ? SQ_KEY2 : SQ_IDLE;
                SQ_KEY2:
                    if (wr_done)
                        state <= key_hit(cmd, KEY_ADDR_HI, KEY_BYTE_3) ? SQ_ARMED : SQ_IDLE;
                SQ_ARMED:
                    if (wr_done) begin
                        target <= cmd;
                        remain <= CNT_W'(PGM_CYCLES - 1);
                        state  <= SQ_BUSY;
                    end
                SQ_BUSY:
                    // writes are not looked at in this state
                    if (remain == '0)
                        state <= SQ_IDLE;
                    else
                        remain <= remain - 1'b1;
                default:
                    state <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = (state == SQ_BUSY);
    assign prog_start = (state == SQ_ARMED) && wr_done;
    assign prog_req   = busy && (remain == '0);

    for (genvar b = 0; b < 2; b++) begin : g_busy
        assign bank_busy[b] = busy && (target.addr[AW-1] == 1'(b));
    end

endmodule

// File: rtl/fps_rdmux.sv
module fps_rdmux
    import fps_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          oe_n,
    input  logic          ce_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [1:0]    bank_busy,
    input  logic          new_bit7,
    input  logic          prog_start,
    output logic [DW-1:0] rdata
);

    logic sel;
    logic hit;
    logic poll_rd;
    logic poll_rd_q;
    logic tgl;

    assign sel     = ~oe_n & ~ce_n;
    assign hit     = bank_busy[addr[AW-1]];
    assign poll_rd = sel & hit;

    always_ff @(posedge clk) begin
        if (rst || prog_start) begin
            tgl       <= 1'b0;
            poll_rd_q <= 1'b0;
        end else begin
            poll_rd_q <= poll_rd;
            if (poll_rd_q && !poll_rd)
                tgl <= ~tgl;
        end
    end

    always_comb begin
        rdata = '0;
        if (poll_rd) begin
            rdata[7] = ~new_bit7;
            rdata[6] = tgl;
        end else if (sel) begin
            rdata = arr_rdata;
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int PGM_CYCLES = 2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] arr_pdata,
    output logic [1:0]    bank_busy,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_wdata
);

    logic    wr_done;
    wr_cmd_t cmd;
    wr_cmd_t target;
    logic    prog_start;

    fps_strobe i_strobe (
        .clk     (clk),
        .rst     (rst),
        .we_n    (we_n),
        .ce_n    (ce_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_done (wr_done),
        .cmd     (cmd)
    );

    fps_ctrl #(.PGM_CYCLES(PGM_CYCLES)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_done    (wr_done),
        .cmd        (cmd),
        .bank_busy  (bank_busy),
        .prog_start (prog_start),
        .prog_req   (prog_req),
        .target     (target)
    );

    fps_rdmux i_rdmux (
        .clk        (clk),
        .rst        (rst),
        .oe_n       (oe_n),
        .ce_n       (ce_n),
        .addr       (addr),
        .arr_rdata  (arr_rdata),
        .bank_busy  (bank_busy),
        .new_bit7   (target.data[7]),
        .prog_start (prog_start),
        .rdata      (rdata)
    );

    // programming can only clear bits
    assign prog_addr  = target.addr;
    assign prog_wdata = target.data & arr_pdata;

endmodule

// File: rtl/fps_checker.sv
module fps_checker
    import fps_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          oe_n,
    input logic          ce_n,
    input logic [DW-1:0] rdata,
    input logic [1:0]    bank_busy,
    input logic          prog_req,
    input logic [AW-1:0] prog_addr
);

    a_r5_single_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_busy));

    a_r9_req_inside_busy: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> (bank_busy != 2'b00));

    a_r9_req_ends_busy: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> (bank_busy == 2'b00));

    a_r6_target_held: assert property (@(posedge clk) disable iff (rst)
        (bank_busy != 2'b00 && !prog_req) |=> ($stable(prog_addr) && $stable(bank_busy)));

    a_r8_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        (oe_n || ce_n) |-> (rdata == '0));

endmodule

bind flash_prog_seq fps_checker i_fps_checker (
    .clk       (clk),
    .rst       (rst),
    .oe_n      (oe_n),
    .ce_n      (ce_n),
    .rdata     (rdata),
    .bank_busy (bank_busy),
    .prog_req  (prog_req),
    .prog_addr (prog_addr)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;
    import fps_pkg::*;

    localparam int PGM = 2000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] arr_pdata;
    logic [1:0]    bank_busy;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_wdata;

    int n_chk = 0;
    int n_bad = 0;

    // small array model: 64 words indexed by bank bit and low five bits
    logic [DW-1:0] mem [64];
    logic          pre_en = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [DW-1:0] pre_val = '0;

    function automatic int widx(input logic [AW-1:0] a);
        return int'({a[AW-1], a[4:0]});
    endfunction

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= '1;
        end else if (pre_en) begin
            mem[widx(pre_addr)] <= pre_val;
        end else if (prog_req) begin
            mem[widx(prog_addr)] <= prog_wdata;
        end
    end

    assign arr_rdata = mem[widx(addr)];
    assign arr_pdata = mem[widx(prog_addr)];

    flash_prog_seq #(.PGM_CYCLES(PGM)) i_flash_prog_seq (
        .clk(clk), .rst(rst), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .arr_rdata(arr_rdata), .arr_pdata(arr_pdata),
        .bank_busy(bank_busy), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_val = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // plain write; returns in the negedge after the completing edge
    task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic unlock();
        host_wr(16'h5555, 16'h00AA);
        host_wr(16'h2AAA, 16'h0055);
        host_wr(16'h5555, 16'h00A0);
    endtask

    task automatic host_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = rdata;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (bank_busy != 2'b00) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", 32'(bank_busy), 32'h0);
        check("R1 req after reset", 32'(prog_req), 32'h0);
        @(negedge clk);
        ce_n = 1'b0; addr = 16'h0001;
        @(negedge clk);
        check("R1 R8 rdata with oe_n high", 32'(rdata), 32'h0);
        ce_n = 1'b1;
    endtask

    task automatic t_plain_read();
        logic [DW-1:0] d;
        preset(16'h8002, 16'hC0DE);
        host_rd(16'h8002, d);
        check("R8 idle read passes array data", 32'(d), 32'hC0DE);
    endtask

    task automatic t_program_bank0();
        logic [DW-1:0] d;
        int n;
        preset(16'h0003, 16'h0F0F);
        preset(16'h8004, 16'hBEEF);
        unlock();
        host_wr(16'h0003, 16'h00FF);
        check("R5 bank0 flag set", 32'(bank_busy), 32'h1);
        n = 0;
        fork
            begin
                while (bank_busy != 2'b00) begin
                    n++;
                    @(negedge clk);
                end
            end
            begin
                host_rd(16'h0003, d);
                check("R7 first poll read", 32'(d), 32'h0000);
                host_rd(16'h0003, d);
                check("R7 second poll read toggles", 32'(d), 32'h0040);
                host_rd(16'h0003, d);
                check("R7 third poll read toggles back", 32'(d), 32'h0000);
                host_rd(16'h8004, d);
                check("R8 other bank read while busy", 32'(d), 32'hBEEF);
                // full key and program to bank1 while bank0 programs
                unlock();
                host_wr(16'h8004, 16'h0000);
                check("R6 no bank1 flag during busy", 32'(bank_busy), 32'h1);
            end
        join
        check("R5 busy duration in cycles", 32'(n), 32'(PGM));
        @(negedge clk);
        host_rd(16'h0003, d);
        check("R9 R10 stored word is new AND old", 32'(d), 32'h000F);
        host_rd(16'h8004, d);
        check("R6 ignored program left bank1 word", 32'(d), 32'hBEEF);
        check("R6 no busy after ignored command", 32'(bank_busy), 32'h0);
    endtask

    task automatic t_bad_key();
        logic [DW-1:0] d;
        preset(16'h0009, 16'h7777);
        host_wr(16'h5555, 16'h00AA);
        host_wr(16'h2AAA, 16'h0056);
        host_wr(16'h5555, 16'h00A0);
        host_wr(16'h0009, 16'h0000);
        @(negedge clk);
        check("R4 broken key starts nothing", 32'(bank_busy), 32'h0);
        host_rd(16'h0009, d);
        check("R4 broken key word unchanged", 32'(d), 32'h7777);
    endtask

    task automatic t_skewed_strobes();
        logic [DW-1:0] d;
        unlock();
        @(negedge clk);
        addr = 16'h8010; wdata = 16'hFFFF; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        addr = 16'h8006;
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        addr = 16'h8011; wdata = 16'h5A5A;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        wdata = 16'h0000;
        @(negedge clk);
        we_n = 1'b1;
        check("R5 bank1 flag from skewed write", 32'(bank_busy), 32'h2);
        wait_idle();
        host_rd(16'h8006, d);
        check("R2 R3 skewed write stored", 32'(d), 32'h5A5A);
        host_rd(16'h8010, d);
        check("R2 early address not used", 32'(d), 32'hFFFF);
        host_rd(16'h8011, d);
        check("R2 late address not used", 32'(d), 32'hFFFF);
    endtask

    task automatic t_req_pulse();
        int n;
        unlock();
        host_wr(16'h8001, 16'h1234);
        n = 0;
        while (bank_busy != 2'b00) begin
            if (prog_req) n++;
            @(negedge clk);
        end
        check("R9 single request cycle", 32'(n), 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_read();
        t_program_bank0();
        t_bad_key();
        t_skewed_strobes();
        t_req_pulse();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule